// File: doc/BRIEF.md
# Host Memory Window Bridge with Posted-Write Buffer

This block places a graphics memory inside a host processor's address map. Host writes to the memory window are posted into a small internal buffer and complete in the cycle they are presented, as long as the buffer has a free slot. Host reads hold the bus with a wait signal until the memory side returns the word. A read is never sent ahead of buffered writes, so the host always reads back what it last wrote.

A DMA controller can also feed the graphics memory in single-address mode. The bridge asks for each unit with a request line. The controller answers with an acknowledge and puts the data word on the host data bus. The bridge keeps its own auto-incrementing counter and takes the graphics-memory address from it. Only cycle-steal operation is supported: the request drops after every accepted unit and rises again only after the acknowledge has been released.

On the memory side there is a single request/grant port with address, direction, byte enables and write data, plus a strobe that marks returned read data. Two host-visible registers control the block. One enables the window and DMA. The other loads the DMA address counter.

Top module: `host_mem_bridge`

## Requirements
- R1: After reset, hst_wait, dma_req and mem_req are low. The window and DMA are disabled and the DMA counter reads 0.
- R2: A window write completes with no wait state while the buffer has a free slot. The buffer holds 32 bytes, which is 8 words at the default 32-bit width. Byte enables go with each word to the memory side, where only the enabled bytes change.
- R3: While the buffer is full, a window write keeps hst_wait high. It completes once an entry has drained to the memory side.
- R4: A window read keeps hst_wait high until the memory side returns data. The read data is on hst_rdata in the cycle hst_wait is low. Each extra cycle of memory read latency adds exactly one wait cycle.
- R5: A read goes to the memory side only when the buffer is empty, so a read returns the value of any earlier buffered write.
- R6: While the window enable (control bit 0) is 0, any window access holds hst_wait high indefinitely. It issues no memory request and changes no memory contents.
- R7: Register accesses (hst_reg_sel) complete with no wait. Address bit 0 = 0 selects control, where bit 0 is the window enable and bit 1 the DMA enable. Address bit 0 = 1 selects the DMA word-address counter. Both read back their value.
- R8: dma_req is high when DMA and the window are enabled, the buffer has space and no read is in progress. A cycle with dma_req and dma_ack both high posts hst_wdata, with all byte enables, at the counter address. The counter then advances by one word.
- R9: After an accepted DMA unit, dma_req is low in the next cycle and stays low while dma_ack remains high.
- R10: The memory request keeps its address, direction and data stable until it is granted. Buffered writes reach the memory in the order they were posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_win_sel | input | 1 | Host access targets the memory window |
| hst_reg_sel | input | 1 | Host access targets the control registers |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | ADDR_W | Host word address |
| hst_be | input | DATA_W/8 | Host byte enables |
| hst_wdata | input | DATA_W | Host write data, also the DMA data word |
| hst_rdata | output | DATA_W | Host read data |
| hst_wait | output | 1 | Hold the current host access |
| dma_req | output | 1 | Request one DMA unit |
| dma_ack | input | 1 | DMA controller is driving a unit |
| mem_req | output | 1 | Memory-side request |
| mem_we | output | 1 | Memory-side write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory side accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
Two internal faults matter most here: an occupancy count that is off, or a read state that skips a step. A wrong count shows up as a wait on a write that should post, or as a lost write, within a few accesses of the buffer filling. A skipped read step shows up as wait dropping early with stale data, or as a read overtaking posted writes, and that appears on the very next read-back. A DMA handshake fault shows at dma_req one cycle after the acknowledge. A counter fault shows when the counter is read back after a few units.

// File: rtl/host_mem_bridge.sv
module host_mem_bridge #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_win_sel,
  input  logic              hst_reg_sel,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W/8-1:0] hst_be,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_wait,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BE_W  = DATA_W / 8;
  localparam int DEPTH = BUF_BYTES / BE_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FULL_N = DEPTH[PTR_W:0];

  typedef enum logic [1:0] {RD_IDLE, RD_ISSUE, RD_DATA, RD_DONE} rd_st_t;

  rd_st_t             rd_st;
  logic               win_en, dma_en, dma_busy;
  logic [ADDR_W-1:0]  dma_cnt, rd_addr;
  logic [DATA_W-1:0]  rd_buf;
  logic [ADDR_W-1:0]  q_addr [DEPTH];
  logic [BE_W-1:0]    q_be   [DEPTH];
  logic [DATA_W-1:0]  q_data [DEPTH];
  logic [PTR_W-1:0]   wp, rp;
  logic [PTR_W:0]     fill;

  wire full     = (fill == FULL_N);
  wire empty    = (fill == '0);
  wire dma_acc  = dma_req & dma_ack;
  wire host_wr  = hst_win_sel & hst_wr & win_en & ~full & ~dma_acc;
  wire push     = dma_acc | host_wr;
  wire rd_issue = (rd_st == RD_ISSUE);
  wire pop      = ~empty & ~rd_issue & mem_gnt;
  wire rd_start = (rd_st == RD_IDLE) & hst_win_sel & hst_rd & win_en & empty & ~dma_acc;
  wire reg_wr   = hst_reg_sel & hst_wr;

  assign dma_req  = dma_en & win_en & ~full & ~dma_busy & (rd_st == RD_IDLE);
  assign hst_wait = hst_win_sel & (~win_en | (hst_wr & (full | dma_acc)) |
                                   (hst_rd & (rd_st != RD_DONE)));
  assign hst_rdata = hst_reg_sel ? (hst_addr[0] ? {{(DATA_W-ADDR_W){1'b0}}, dma_cnt}
                                                : {{(DATA_W-2){1'b0}}, dma_en, win_en})
                                 : rd_buf;

  assign mem_req   = rd_issue | ~empty;
  assign mem_we    = ~rd_issue;
  assign mem_addr  = rd_issue ? rd_addr : q_addr[rp];
  assign mem_be    = rd_issue ? {BE_W{1'b1}} : q_be[rp];
  assign mem_wdata = q_data[rp];

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= dma_acc ? dma_cnt : hst_addr;
      q_be[wp]   <= dma_acc ? {BE_W{1'b1}} : hst_be;
      q_data[wp] <= hst_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fill <= fill + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en   <= 1'b0;
      dma_en   <= 1'b0;
      dma_cnt  <= '0;
      dma_busy <= 1'b0;
    end else begin
      if (reg_wr && !hst_addr[0]) begin
        win_en <= hst_wdata[0];
        dma_en <= hst_wdata[1];
      end
      if (reg_wr && hst_addr[0]) dma_cnt <= hst_wdata[ADDR_W-1:0];
      else if (dma_acc)          dma_cnt <= dma_cnt + 1'b1;
      if (dma_acc)       dma_busy <= 1'b1;
      else if (!dma_ack) dma_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_st   <= RD_IDLE;
      rd_addr <= '0;
      rd_buf  <= '0;
    end else begin
      case (rd_st)
        RD_IDLE:  if (rd_start) begin
                    rd_st   <= RD_ISSUE;
                    rd_addr <= hst_addr;
                  end
        RD_ISSUE: if (mem_gnt) rd_st <= RD_DATA;
        RD_DATA:  if (mem_rvalid) begin
                    rd_st  <= RD_DONE;
                    rd_buf <= mem_rdata;
                  end
        default:  rd_st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/host_mem_bridge_chk.sv
module host_mem_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 3,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_win_sel,
  input logic              hst_reg_sel,
  input logic              hst_wr,
  input logic              hst_wait,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              win_en,
  input logic [PTR_W:0]    fill,
  input logic [ADDR_W-1:0] dma_cnt
);
  a_r2_post_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    hst_win_sel && hst_wr && win_en && (fill < DEPTH) && !dma_ack |-> !hst_wait);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH);

  a_r6_locked_wait: assert property (@(posedge clk) disable iff (!rst_n)
    hst_win_sel && !win_en |-> hst_wait);

  a_r5_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> fill == '0);

  a_r9_req_release: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack |=> !dma_req);

  a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack && !(hst_reg_sel && hst_wr) |=> dma_cnt == $past(dma_cnt) + 1'b1);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            (!mem_we || $stable(mem_wdata)));
endmodule

bind host_mem_bridge host_mem_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_win_sel(hst_win_sel), .hst_reg_sel(hst_reg_sel),
  .hst_wr(hst_wr), .hst_wait(hst_wait), .dma_req(dma_req), .dma_ack(dma_ack),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .win_en(win_en), .fill(fill), .dma_cnt(dma_cnt)
);

// File: tb/host_mem_bridge_tb.sv
module host_mem_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        hst_win_sel = 0, hst_reg_sel = 0, hst_wr = 0, hst_rd = 0;
  logic [15:0] hst_addr = '0;
  logic [3:0]  hst_be = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic        hst_wait, dma_req, dma_ack = 0;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid = 0;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;

  host_mem_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .hst_win_sel(hst_win_sel), .hst_reg_sel(hst_reg_sel),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_be(hst_be),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_wait(hst_wait),
    .dma_req(dma_req), .dma_ack(dma_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] mem [64];
  logic        gnt_allow = 1'b1;
  int          lat = 1;
  int          lat_cnt = 0;
  logic        pend = 0;
  logic [5:0]  pend_addr = '0;
  logic        req_seen = 0;
  assign mem_gnt = mem_req & gnt_allow;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) req_seen <= 1'b1;
    if (mem_req && mem_gnt && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_req && mem_gnt && !mem_we) begin
      pend <= 1'b1; lat_cnt <= lat; pend_addr <= mem_addr[5:0];
    end else if (pend) begin
      if (lat_cnt <= 1) begin
        pend <= 1'b0; mem_rvalid <= 1'b1; mem_rdata <= mem[pend_addr];
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hop(input bit is_reg, input bit wr, input logic [15:0] a,
                     input logic [31:0] d, input logic [3:0] be, input int limit,
                     output int nw, output logic [31:0] rd);
    @(negedge clk);
    hst_win_sel = !is_reg; hst_reg_sel = is_reg; hst_wr = wr; hst_rd = !wr;
    hst_addr = a; hst_wdata = d; hst_be = be;
    #1;
    nw = 0;
    while (hst_wait && nw < limit) begin @(negedge clk); #1; nw++; end
    rd = hst_rdata;
    @(negedge clk);
    hst_win_sel = 0; hst_reg_sel = 0; hst_wr = 0; hst_rd = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(!hst_wait && !dma_req && !mem_req, "R1 idle outputs", {hst_wait, dma_req, mem_req}, 0);
  endtask

  task automatic t_locked;
    int n; logic [31:0] r;
    req_seen = 0;
    hop(0, 1, 16'd5, 32'hDEAD_BEEF, 4'hF, 20, n, r);
    chk(n == 20, "R6 write held", n, 20);
    hop(0, 0, 16'd5, 0, 4'hF, 20, n, r);
    chk(n == 20, "R6 read held", n, 20);
    chk(!req_seen, "R6 no mem request", req_seen, 0);
    hop(1, 0, 16'd0, 0, 0, 5, n, r);
    chk(r == 0, "R1 control reset", r, 0);
    hop(1, 0, 16'd1, 0, 0, 5, n, r);
    chk(r == 0, "R1 counter reset", r, 0);
  endtask

  task automatic t_regs;
    int n; logic [31:0] r;
    hop(1, 1, 16'd0, 32'h1, 4'hF, 5, n, r);
    chk(n == 0, "R7 reg write no wait", n, 0);
    hop(1, 0, 16'd0, 0, 0, 5, n, r);
    chk(r == 32'h1 && n == 0, "R7 control readback", r, 1);
    hop(0, 0, 16'd5, 0, 4'hF, 100, n, r);
    chk(r == 0, "R6 locked write left no data", r, 0);
  endtask

  task automatic t_fill;
    int n; int bad = 0; logic [31:0] r;
    gnt_allow = 0;
    for (int i = 0; i < 8; i++) begin
      hop(0, 1, 16'(i), 32'hA000 + i, 4'hF, 100, n, r);
      if (n != 0) bad++;
    end
    chk(bad == 0, "R2 eight posted writes no wait", bad, 0);
    fork
      hop(0, 1, 16'd8, 32'hA008, 4'hF, 100, n, r);
      begin repeat (6) @(negedge clk); gnt_allow = 1; end
    join
    chk(n >= 5 && n <= 8, "R3 full buffer waits", n, 6);
    bad = 0;
    for (int i = 0; i < 9; i++) begin
      hop(0, 0, 16'(i), 0, 4'hF, 100, n, r);
      if (r != 32'hA000 + i) begin
        bad++;
        $display("FAIL R10 word %0d: actual 0x%0h expected 0x%0h", i, r, 32'hA000 + i);
      end
    end
    chk(bad == 0, "R10 drained in order", bad, 0);
  endtask

  task automatic t_order;
    int n; logic [31:0] r;
    gnt_allow = 0;
    hop(0, 1, 16'd20, 32'h5A5A_1234, 4'hF, 100, n, r);
    fork
      hop(0, 0, 16'd20, 0, 4'hF, 100, n, r);
      begin repeat (3) @(negedge clk); gnt_allow = 1; end
    join
    chk(r == 32'h5A5A_1234, "R5 read sees buffered write", r, 32'h5A5A_1234);
    hop(0, 1, 16'd30, 32'hFFFF_FFFF, 4'hF, 100, n, r);
    hop(0, 1, 16'd30, 32'h1234_5678, 4'h3, 100, n, r);
    hop(0, 0, 16'd30, 0, 4'hF, 100, n, r);
    chk(r == 32'hFFFF_5678, "R2 byte enables", r, 32'hFFFF_5678);
  endtask

  task automatic t_latency;
    int n1, n5; logic [31:0] r;
    lat = 1;
    hop(0, 0, 16'd20, 0, 4'hF, 100, n1, r);
    chk(n1 > 0, "R4 read inserts waits", n1, 1);
    lat = 5;
    hop(0, 0, 16'd20, 0, 4'hF, 100, n5, r);
    chk(n5 - n1 == 4, "R4 waits track latency", n5 - n1, 4);
    chk(r == 32'h5A5A_1234, "R4 read data", r, 32'h5A5A_1234);
    lat = 1;
  endtask

  task automatic t_dma;
    int n; int bad = 0; logic [31:0] r;
    hop(1, 1, 16'd1, 32'h10, 4'hF, 5, n, r);
    hop(1, 0, 16'd1, 0, 0, 5, n, r);
    chk(r == 32'h10, "R7 counter load", r, 32'h10);
    hop(1, 1, 16'd0, 32'h3, 4'hF, 5, n, r);
    for (int k = 0; k < 3; k++) begin
      int g = 0;
      @(negedge clk); #1;
      while (!dma_req && g < 50) begin @(negedge clk); #1; g++; end
      if (!dma_req) bad++;
      dma_ack = 1; hst_wdata = 32'hC0DE_0000 + k;
      @(negedge clk); #1;
      chk(!dma_req, "R9 request released after unit", dma_req, 0);
      @(negedge clk); #1;
      chk(!dma_req, "R9 low while ack held", dma_req, 0);
      dma_ack = 0;
    end
    chk(bad == 0, "R8 request raised", bad, 0);
    hop(1, 1, 16'd0, 32'h1, 4'hF, 5, n, r);
    hop(1, 0, 16'd1, 0, 0, 5, n, r);
    chk(r == 32'h13, "R8 counter advanced", r, 32'h13);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      hop(0, 0, 16'(16 + k), 0, 4'hF, 100, n, r);
      if (r != 32'hC0DE_0000 + k) bad++;
    end
    chk(bad == 0, "R8 DMA data at counter addresses", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_locked;
    t_regs;
    t_fill;
    t_order;
    t_latency;
    t_dma;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule